// File: doc/BRIEF.md
# Flash IAP Command Sequencer

This block lets software running on a processor read, program and erase an on-chip data flash area through six byte-wide registers. Software first loads a 16-bit flash address (two bytes), a data byte and a command code, and sets the enable bit in the control register. It then writes a two-byte unlock key to the trigger register. When the second key byte arrives, the sequencer runs exactly one operation against the flash array. While it runs, the busy output is high and the register file is frozen.

A read places the addressed byte in the data register a fixed number of cycles after the key completes. A program may only clear bits: the stored byte becomes the old byte ANDed with the data register. An erase walks the whole 512-byte sector that holds the address and sets each byte to 0xFF, one byte per cycle. If an operation names an address beyond the implemented array, it sets a fail flag and touches nothing. The array is a behavioural memory inside the block, reset to the erased state.

Top module: `flash_iap_seq`

## Requirements
- R1: After reset every register reads 0x00, busy and fail are low, and every flash byte reads back as 0xFF.
- R2: Register offsets on regAddr are 0 address high, 1 address low, 2 data, 3 command, 4 control, 5 trigger. The first five read back what was last written. The trigger offset and offsets 6 and 7 read 0x00.
- R3: An operation starts only on the trigger write of 0xA5 whose previous trigger write was 0x5A, with control bit 7 set at both writes. Every trigger write that does not start an operation leaves the block armed only if its value is 0x5A with the enable set. Writes to other registers do not disturb the armed state.
- R4: While control bit 7 is clear, trigger writes start nothing and do not arm.
- R5: Command 0x01 (read) holds busy high for exactly 2 cycles after the launching write. When busy falls, the data register holds the addressed byte.
- R6: Command 0x02 (program) holds busy for exactly 4 cycles and leaves the addressed byte equal to its old value ANDed with the data register, so bits only go from 1 to 0.
- R7: Command 0x03 (erase) holds busy for exactly 512 cycles and sets every byte of the addressed 512-byte sector to 0xFF. Bytes of other sectors are unchanged.
- R8: Command 0x00 and codes 0x04 to 0xFF start nothing: busy stays low, and memory and the fail flag are unchanged.
- R9: A read, program or erase whose 16-bit address is 1024 or more raises fail, does not raise busy, and leaves memory and the data register unchanged. Fail stays high until the next in-range read, program or erase launches, which clears it.
- R10: While busy is high, writes to any register, the trigger included, are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous active-low reset |
| regWe | input | 1 | Register write strobe, one write per cycle |
| regAddr | input | 3 | Register offset for write and read |
| regWdata | input | 8 | Write data |
| regRdata | output | 8 | Combinational read data of the register at regAddr |
| busy | output | 1 | High while an operation runs |
| fail | output | 1 | Last launched operation addressed outside the array |

## Verification
The hardest situation to reach from the ports is a register write landing in the middle of a running operation, because that window only exists for a handful of cycles. For read and program it is very short; the 512-cycle erase gives the longest window. The bench starts an erase and, without waiting, writes every register and replays the full unlock key while busy is still high. It then reads each register back and confirms that no second operation followed. Broken unlock orders (a stray value between the key bytes, a repeated first byte, an interleaved address write, the enable dropped between the bytes) are each driven and judged by whether busy rises on the following cycle.

// File: rtl/iap_pkg.sv
package iap_pkg;

  localparam logic [2:0] REG_ADDR_HI = 3'd0;
  localparam logic [2:0] REG_ADDR_LO = 3'd1;
  localparam logic [2:0] REG_DATA    = 3'd2;
  localparam logic [2:0] REG_CMD     = 3'd3;
  localparam logic [2:0] REG_CTRL    = 3'd4;
  localparam logic [2:0] REG_TRIG    = 3'd5;

  localparam logic [7:0] KEY_FIRST  = 8'h5A;
  localparam logic [7:0] KEY_SECOND = 8'hA5;

  // encodings equal the low two bits of the command codes 0x01..0x03
  typedef enum logic [1:0] {
    OP_NONE  = 2'd0,
    OP_READ  = 2'd1,
    OP_PROG  = 2'd2,
    OP_ERASE = 2'd3
  } iap_op_e;

  typedef struct packed {
    logic wrAddrHi;
    logic wrAddrLo;
    logic wrData;
    logic wrCmd;
    logic wrCtrl;
    logic capRead;
    logic progByte;
    logic eraseByte;
  } iap_strobe_t;

endpackage

// File: rtl/iap_ctrl.sv
module iap_ctrl
  import iap_pkg::*;
#(
  parameter int SECTOR_BYTES = 512,
  parameter int READ_LAT     = 2,
  parameter int PROG_LAT     = 4
) (
  input  logic                            clk,
  input  logic                            rstN,
  input  logic                            regWe,
  input  logic [2:0]                      regAddr,
  input  logic [7:0]                      regWdata,
  input  logic                            ctrlEn,
  input  logic [7:0]                      cmdVal,
  input  logic                            addrOk,
  output logic                            busy,
  output logic                            fail,
  output iap_strobe_t                     strb,
  output logic [$clog2(SECTOR_BYTES)-1:0] eraseOff
);

  localparam int SEC_AW  = $clog2(SECTOR_BYTES);
  localparam int MAX_LAT = (READ_LAT > PROG_LAT) ? READ_LAT : PROG_LAT;
  localparam int CNT_W   = $clog2(MAX_LAT + 1);
  localparam logic [SEC_AW-1:0] SEC_LAST = SEC_AW'(SECTOR_BYTES - 1);
  localparam logic [CNT_W-1:0]  RD_LOAD  = CNT_W'(READ_LAT - 1);
  localparam logic [CNT_W-1:0]  PG_LOAD  = CNT_W'(PROG_LAT - 1);

  logic             armed;
  iap_op_e          op;
  logic [CNT_W-1:0] cnt;
  logic             trigWr;
  logic             launch;
  logic             cmdKnown;

  assign trigWr   = regWe && !busy && (regAddr == REG_TRIG);
  assign launch   = trigWr && armed && ctrlEn && (regWdata == KEY_SECOND);
  assign cmdKnown = (cmdVal == 8'h01) || (cmdVal == 8'h02) || (cmdVal == 8'h03);

  always_comb begin
    strb = '0;
    if (regWe && !busy) begin
      case (regAddr)
        REG_ADDR_HI: strb.wrAddrHi = 1'b1;
        REG_ADDR_LO: strb.wrAddrLo = 1'b1;
        REG_DATA:    strb.wrData   = 1'b1;
        REG_CMD:     strb.wrCmd    = 1'b1;
        REG_CTRL:    strb.wrCtrl   = 1'b1;
        default: ;
      endcase
    end
    if (busy) begin
      case (op)
        OP_READ:  strb.capRead   = (cnt == '0);
        OP_PROG:  strb.progByte  = (cnt == '0);
        OP_ERASE: strb.eraseByte = 1'b1;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      armed    <= 1'b0;
      busy     <= 1'b0;
      fail     <= 1'b0;
      op       <= OP_NONE;
      cnt      <= '0;
      eraseOff <= '0;
    end else begin
      if (trigWr) begin
        armed <= ctrlEn && (regWdata == KEY_FIRST);
      end
      if (launch && cmdKnown) begin
        if (!addrOk) begin
          fail <= 1'b1;
        end else begin
          fail     <= 1'b0;
          busy     <= 1'b1;
          op       <= iap_op_e'(cmdVal[1:0]);
          eraseOff <= '0;
          cnt      <= (cmdVal[1:0] == 2'd1) ? RD_LOAD : PG_LOAD;
        end
      end else if (busy) begin
        if (op == OP_ERASE) begin
          eraseOff <= eraseOff + 1'b1;
          if (eraseOff == SEC_LAST) busy <= 1'b0;
        end else if (cnt == '0) begin
          busy <= 1'b0;
        end else begin
          cnt <= cnt - 1'b1;
        end
      end
    end
  end

  // R3
  launch_by_key_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busy) |-> $past(regWe && regAddr == REG_TRIG && regWdata == KEY_SECOND));

  // R4
  launch_needs_enable_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busy) |-> $past(ctrlEn));

  // R9
  fail_from_bad_addr_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(fail) |-> $past(regWe && regAddr == REG_TRIG && !addrOk));

  // R9
  bad_addr_no_busy_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(fail) |-> !busy);

endmodule

// File: rtl/iap_datapath.sv
module iap_datapath
  import iap_pkg::*;
#(
  parameter int MEM_BYTES    = 1024,
  parameter int SECTOR_BYTES = 512
) (
  input  logic                            clk,
  input  logic                            rstN,
  input  iap_strobe_t                     strb,
  input  logic [$clog2(SECTOR_BYTES)-1:0] eraseOff,
  input  logic                            busy,
  input  logic [2:0]                      regAddr,
  input  logic [7:0]                      regWdata,
  output logic [7:0]                      regRdata,
  output logic                            ctrlEn,
  output logic [7:0]                      cmdVal,
  output logic                            addrOk
);

  localparam int MEM_AW = $clog2(MEM_BYTES);
  localparam int SEC_AW = $clog2(SECTOR_BYTES);

  logic [7:0]        addrHi, addrLo, dataReg, cmdReg, ctrlReg;
  logic [15:0]       addrFull;
  logic [MEM_AW-1:0] memIdx;
  logic [MEM_AW-1:0] eraseIdx;
  logic [7:0]        memArr [MEM_BYTES];

  assign addrFull = {addrHi, addrLo};
  assign addrOk   = (32'(addrFull) < 32'(MEM_BYTES));
  assign memIdx   = addrFull[MEM_AW-1:0];
  assign eraseIdx = {memIdx[MEM_AW-1:SEC_AW], eraseOff};
  assign ctrlEn   = ctrlReg[7];
  assign cmdVal   = cmdReg;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      addrHi  <= '0;
      addrLo  <= '0;
      dataReg <= '0;
      cmdReg  <= '0;
      ctrlReg <= '0;
    end else begin
      if (strb.wrAddrHi) addrHi  <= regWdata;
      if (strb.wrAddrLo) addrLo  <= regWdata;
      if (strb.wrCmd)    cmdReg  <= regWdata;
      if (strb.wrCtrl)   ctrlReg <= regWdata;
      if (strb.wrData)   dataReg <= regWdata;
      else if (strb.capRead) dataReg <= memArr[memIdx];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < MEM_BYTES; i++) memArr[i] <= 8'hFF;
    end else if (strb.progByte) begin
      memArr[memIdx] <= memArr[memIdx] & dataReg;
    end else if (strb.eraseByte) begin
      memArr[eraseIdx] <= 8'hFF;
    end
  end

  always_comb begin
    case (regAddr)
      REG_ADDR_HI: regRdata = addrHi;
      REG_ADDR_LO: regRdata = addrLo;
      REG_DATA:    regRdata = dataReg;
      REG_CMD:     regRdata = cmdReg;
      REG_CTRL:    regRdata = ctrlReg;
      default:     regRdata = 8'h00;
    endcase
  end

  // R2
  strobe_exclusive_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strb.wrAddrHi, strb.wrAddrLo, strb.wrData, strb.wrCmd, strb.wrCtrl,
              strb.capRead, strb.progByte, strb.eraseByte}));

  // R10
  regs_frozen_chk: assert property (@(posedge clk) disable iff (!rstN)
    busy |=> $stable({addrHi, addrLo, cmdReg, ctrlReg}));

  // R10
  data_frozen_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busy && !strb.capRead) |=> $stable(dataReg));

  // R6
  prog_only_clears_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.progByte |=> ((memArr[$past(memIdx)] & ~$past(memArr[memIdx])) == 8'h00));

  // R7
  erase_sets_ff_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.eraseByte |=> (memArr[$past(eraseIdx)] == 8'hFF));

endmodule

// File: rtl/flash_iap_seq.sv
module flash_iap_seq
  import iap_pkg::*;
#(
  parameter int MEM_BYTES    = 1024,
  parameter int SECTOR_BYTES = 512,
  parameter int READ_LAT     = 2,
  parameter int PROG_LAT     = 4
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       regWe,
  input  logic [2:0] regAddr,
  input  logic [7:0] regWdata,
  output logic [7:0] regRdata,
  output logic       busy,
  output logic       fail
);

  localparam int SEC_AW = $clog2(SECTOR_BYTES);

  iap_strobe_t       strb;
  logic [SEC_AW-1:0] eraseOff;
  logic              ctrlEn;
  logic [7:0]        cmdVal;
  logic              addrOk;

  iap_ctrl #(
    .SECTOR_BYTES(SECTOR_BYTES),
    .READ_LAT    (READ_LAT),
    .PROG_LAT    (PROG_LAT)
  ) uCtrl (
    .clk     (clk),
    .rstN    (rstN),
    .regWe   (regWe),
    .regAddr (regAddr),
    .regWdata(regWdata),
    .ctrlEn  (ctrlEn),
    .cmdVal  (cmdVal),
    .addrOk  (addrOk),
    .busy    (busy),
    .fail    (fail),
    .strb    (strb),
    .eraseOff(eraseOff)
  );

  iap_datapath #(
    .MEM_BYTES   (MEM_BYTES),
    .SECTOR_BYTES(SECTOR_BYTES)
  ) uDp (
    .clk     (clk),
    .rstN    (rstN),
    .strb    (strb),
    .eraseOff(eraseOff),
    .busy    (busy),
    .regAddr (regAddr),
    .regWdata(regWdata),
    .regRdata(regRdata),
    .ctrlEn  (ctrlEn),
    .cmdVal  (cmdVal),
    .addrOk  (addrOk)
  );

endmodule

// File: tb/sim_flash_iap_seq.sv
module sim_flash_iap_seq;

  localparam int CLK_PERIOD = 10;
  localparam int MEM        = 1024;
  localparam int SEC        = 512;
  localparam int WATCHDOG   = 190000;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       regWe = 1'b0;
  logic [2:0] regAddr = 3'd0;
  logic [7:0] regWdata = 8'h00;
  logic [7:0] regRdata;
  logic       busy;
  logic       fail;

  int nChk = 0;
  int nFail = 0;
  logic [7:0] model [MEM];

  flash_iap_seq u0 (
    .clk(clk), .rstN(rstN), .regWe(regWe), .regAddr(regAddr),
    .regWdata(regWdata), .regRdata(regRdata), .busy(busy), .fail(fail)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    nChk++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    regWe = 1'b1; regAddr = a; regWdata = d;
    @(posedge clk);
    @(negedge clk);
    regWe = 1'b0;
  endtask

  task automatic rdReg(input logic [2:0] a, output logic [7:0] v);
    regAddr = a;
    #1;
    v = regRdata;
  endtask

  task automatic waitIdle(output int n);
    n = 0;
    while (busy && n < 2000) begin
      n++;
      @(negedge clk);
    end
  endtask

  task automatic setup(input logic [7:0] cmd, input int addr, input logic [7:0] d);
    wr(3'd0, 8'(addr >> 8));
    wr(3'd1, 8'(addr));
    wr(3'd2, d);
    wr(3'd3, cmd);
  endtask

  task automatic key();
    wr(3'd5, 8'h5A);
    wr(3'd5, 8'hA5);
  endtask

  task automatic doOp(input logic [7:0] cmd, input int addr, input logic [7:0] d, output int n);
    setup(cmd, addr, d);
    key();
    waitIdle(n);
  endtask

  task automatic readByte(input int addr, output logic [7:0] v, output int n);
    doOp(8'h01, addr, 8'h00, n);
    rdReg(3'd2, v);
  endtask

  task automatic sweepAll(input string req);
    logic [7:0] v;
    int n;
    for (int a = 0; a < MEM; a++) begin
      readByte(a, v, n);
      check(v == model[a], req, v, model[a]);
    end
  endtask

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    nFail++;
    $display("FAIL watchdog actual=0x0 expected=0x1");
    $display("== %0d vectors applied, %0d miscompares ==", nChk, nFail);
    $finish;
  end

  initial begin
    logic [7:0] v;
    int n;
    logic [7:0] pa;
    for (int a = 0; a < MEM; a++) model[a] = 8'hFF;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1: reset state
    for (int r = 0; r < 8; r++) begin
      rdReg(3'(r), v);
      check(v == 8'h00, "R1 reg reset", v, 0);
    end
    check(busy == 1'b0, "R1 busy reset", busy, 0);
    check(fail == 1'b0, "R1 fail reset", fail, 0);

    // R2: register readback sweep
    for (int k = 0; k < 4; k++) begin
      for (int r = 0; r < 8; r++) begin
        if (r != 5) wr(3'(r), 8'(r * 29 + k * 83 + 1) & 8'h7F);
      end
      for (int r = 0; r < 8; r++) begin
        rdReg(3'(r), v);
        if (r < 5) check(v == (8'(r * 29 + k * 83 + 1) & 8'h7F), "R2 readback", v, 8'(r * 29 + k * 83 + 1) & 8'h7F);
        else check(v == 8'h00, "R2 unmapped reads zero", v, 0);
      end
      check(busy == 1'b0, "R2 no launch", busy, 0);
    end

    wr(3'd4, 8'h81);
    // R1: erased array, R5 read latency
    for (int a = 0; a < MEM; a++) begin
      readByte(a, v, n);
      check(v == 8'hFF, "R1 erased byte", v, 8'hFF);
      if (a % 64 == 0) check(n == 2, "R5 read busy cycles", n, 2);
    end

    // R6: program two passes, bits only clear
    for (int p = 0; p < 2; p++) begin
      for (int a = 0; a < MEM; a++) begin
        pa = (p == 0) ? 8'((a * 37 + 11) ^ (a >> 2)) : 8'((a * 91 + 200) | (a >> 5));
        doOp(8'h02, a, pa, n);
        model[a] = model[a] & pa;
        if (a % 64 == 0) check(n == 4, "R6 program busy cycles", n, 4);
      end
    end
    sweepAll("R6 programmed value");

    // R7 + R10: erase sector 0, writes during busy ignored
    setup(8'h03, 16'h0123, 8'h3C);
    key();
    check(busy == 1'b1, "R7 erase started", busy, 1);
    wr(3'd0, 8'h02); wr(3'd1, 8'h77); wr(3'd2, 8'h66);
    wr(3'd3, 8'h02); wr(3'd4, 8'h00);
    key();
    waitIdle(n);
    check(n + 7 == SEC, "R7 erase busy cycles", n + 7, SEC);
    @(negedge clk);
    check(busy == 1'b0, "R10 key while busy ignored", busy, 0);
    rdReg(3'd0, v); check(v == 8'h01, "R10 addrHi frozen", v, 8'h01);
    rdReg(3'd1, v); check(v == 8'h23, "R10 addrLo frozen", v, 8'h23);
    rdReg(3'd2, v); check(v == 8'h3C, "R10 data frozen", v, 8'h3C);
    rdReg(3'd3, v); check(v == 8'h03, "R10 cmd frozen", v, 8'h03);
    rdReg(3'd4, v); check(v == 8'h81, "R10 ctrl frozen", v, 8'h81);
    for (int a = 0; a < SEC; a++) model[a] = 8'hFF;
    sweepAll("R7 sector erase");

    // R9: out-of-range addresses
    setup(8'h01, 16'h0400, 8'h5C); key();
    check(busy == 1'b0, "R9 no busy on bad read", busy, 1'b0);
    check(fail == 1'b1, "R9 fail on bad read", fail, 1);
    rdReg(3'd2, v); check(v == 8'h5C, "R9 data unchanged", v, 8'h5C);
    setup(8'h02, 16'hFFFF, 8'h00); key();
    check(busy == 1'b0 && fail == 1'b1, "R9 bad program", {busy, fail}, 1);
    setup(8'h03, 16'h8000, 8'h00); key();
    check(busy == 1'b0 && fail == 1'b1, "R9 bad erase", {busy, fail}, 1);

    // R8: no-op codes keep fail, no busy
    setup(8'h00, 16'h0005, 8'h00); key();
    check(busy == 1'b0 && fail == 1'b1, "R8 cmd 0x00 no-op", {busy, fail}, 1);
    setup(8'h07, 16'h0005, 8'h00); key();
    check(busy == 1'b0 && fail == 1'b1, "R8 cmd 0x07 no-op", {busy, fail}, 1);
    readByte(5, v, n);
    check(fail == 1'b0, "R9 fail cleared by good launch", fail, 0);
    check(v == model[5], "R8 memory unchanged", v, model[5]);

    // R4: enable clear
    wr(3'd4, 8'h01);
    setup(8'h02, 16'h0206, 8'h00); key();
    check(busy == 1'b0, "R4 disabled key ignored", busy, 0);
    wr(3'd5, 8'h5A); wr(3'd4, 8'h81); wr(3'd5, 8'hA5);
    check(busy == 1'b0, "R4 arm while disabled ignored", busy, 0);

    // R3: unlock ordering
    setup(8'h01, 16'h0206, 8'h00);
    wr(3'd5, 8'h5A); wr(3'd5, 8'h00); wr(3'd5, 8'hA5);
    check(busy == 1'b0, "R3 stray byte cancels", busy, 0);
    wr(3'd5, 8'hA5);
    check(busy == 1'b0, "R3 lone second byte", busy, 0);
    wr(3'd5, 8'h5A); wr(3'd4, 8'h01); wr(3'd5, 8'hA5);
    check(busy == 1'b0, "R3 enable dropped between keys", busy, 0);
    wr(3'd4, 8'h81);
    wr(3'd5, 8'h5A); wr(3'd5, 8'h5A); wr(3'd5, 8'hA5);
    check(busy == 1'b1, "R3 repeated first byte launches", busy, 1);
    waitIdle(n);
    rdReg(3'd2, v); check(v == model[16'h206], "R3 read after relaunch", v, model[16'h206]);
    wr(3'd5, 8'h5A); wr(3'd1, 8'h07); wr(3'd5, 8'hA5);
    check(busy == 1'b1, "R3 other reg write keeps arm", busy, 1);
    waitIdle(n);
    rdReg(3'd2, v); check(v == model[16'h207], "R3 read interleaved", v, model[16'h207]);

    // R7: erase sector 1, sector 0 intact
    doOp(8'h03, 16'h03FF, 8'h00, n);
    check(n == SEC, "R7 second erase cycles", n, SEC);
    for (int a = SEC; a < MEM; a++) model[a] = 8'hFF;
    for (int a = 0; a < MEM; a += 7) begin
      readByte(a, v, n);
      check(v == model[a], "R7 final contents", v, model[a]);
    end

    $display("== %0d vectors applied, %0d miscompares ==", nChk, nFail);
    $finish;
  end

endmodule